// File: doc/BRIEF.md
# Program-Step Triggered Capture Bank

This block holds eight capture registers that take snapshots of values inside a DSP datapath. Each register has its own setup word. The setup word names a program step and one of four internal source buses. On the clock edge where the core's program counter equals that step, the register loads the chosen bus. It then keeps that value until its step comes around again.

The four sources are:
- the multiplier product, in 1.23 format;
- the dB-conversion result, in 5.19 format;
- the multiplier data operand, in 3.21 format;
- the coefficient operand, in 2.20 format.

The coefficient bus is 22 bits wide and is stored right-aligned in a 24-bit word.

Software programs the setup words through a write port that covers eight consecutive addresses starting at 266. The first two captures can be read back through a register read port at their own setup addresses. The other six are presented side by side to a serial output stage.

Top module: `capture_bank`

## Requirements
- R1: A write with `cfgWrEn` high to address 266+i (i = 0..7) loads setup i from `cfgWrData`. Bits [10:2] are the step count and bits [1:0] are the source select.
- R2: Capture i loads its selected source on the clock edge where `pc` equals its step count (0 to 511). The new value is visible at the outputs right after that edge.
- R3: Select 00 picks `mulOut`, 01 picks `dbOut`, 10 picks `mulDin` and 11 picks `coefIn`. `coefIn` is zero-extended, so bits [23:22] of the captured word are 0.
- R4: A capture keeps its value on every edge where `pc` does not equal its step count.
- R5: Any number of captures may share one step count. All of them load their own selected source on the same edge.
- R6: Writes to addresses outside 266..273 change no setup.
- R7: `rdData` shows capture 0 when `rdAddr` is 266 and capture 1 when it is 267. It is zero for any other address.
- R8: `serWords` bits [24k+23:24k] show capture k+2, for k = 0..5.
- R9: Reset clears all eight captures to zero and all setups to step 0 with select 00.
- R10: A setup written on the same edge as a match does not affect that edge. The capture on that edge uses the old setup, and the new setup applies from the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pc | input | 9 | Core program counter |
| mulOut | input | 24 | Multiplier product bus (1.23) |
| dbOut | input | 24 | dB-conversion bus (5.19) |
| mulDin | input | 24 | Multiplier data operand bus (3.21) |
| coefIn | input | 22 | Coefficient operand bus (2.20) |
| cfgWrEn | input | 1 | Setup write strobe |
| cfgAddr | input | 9 | Setup write address |
| cfgWrData | input | 11 | Setup word {step[8:0], select[1:0]} |
| rdAddr | input | 9 | Register read address |
| rdData | output | 24 | Read data for captures 0 and 1 |
| serWords | output | 144 | Captures 2..7 packed for the serial stage |

## Verification
The in-line assertions check four things on every cycle:
- a setup moves only when its own address is written, and then takes the written word;
- a capture stays constant unless it matched on the edge before;
- a capture from the multiplier product equals that bus one cycle earlier;
- a coefficient capture has zero upper bits.

Some behaviour only the bench's scenarios can show. These are the complete match/select sweep over every program step, shared steps, writes to unmapped addresses, the ordering of a setup write against a match on the same edge, and the read-port decode.

// File: rtl/capture_bank_pkg.sv
package capture_bank_pkg;
  localparam int NUM_CAP   = 8;
  localparam int NUM_RD    = 2;
  localparam int NUM_SER   = NUM_CAP - NUM_RD;
  localparam int STEP_W    = 9;
  localparam int SEL_W     = 2;
  localparam int SETUP_W   = STEP_W + SEL_W;
  localparam int DATA_W    = 24;
  localparam int COEF_W    = 22;
  localparam int ADDR_W    = 9;
  localparam int BASE_ADDR = 266;

  typedef enum logic [SEL_W-1:0] {
    SRC_MUL_OUT = 2'b00,
    SRC_DB_OUT  = 2'b01,
    SRC_MUL_DIN = 2'b10,
    SRC_COEF    = 2'b11
  } srcSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NUM_CAP-1:0]            capEn;
    logic [NUM_CAP-1:0][SEL_W-1:0] capSel;
  } capStrobe_t;
endpackage

// File: rtl/capture_bank_ctrl.sv
module capture_bank_ctrl
  import capture_bank_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [STEP_W-1:0]   pc,
  input  logic                cfgWrEn,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic [SETUP_W-1:0]  cfgWrData,
  output capStrobe_t          strobe
);
  logic [NUM_CAP-1:0]             wrHit;
  logic [NUM_CAP-1:0][STEP_W-1:0] setupStep;
  logic [NUM_CAP-1:0][SEL_W-1:0]  setupSel;

  for (genvar g = 0; g < NUM_CAP; g++) begin : gSetup
    assign wrHit[g] = cfgWrEn && (cfgAddr == ADDR_W'(BASE_ADDR + g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        setupStep[g] <= '0;
        setupSel[g]  <= SRC_MUL_OUT;
      end else if (wrHit[g]) begin
        setupStep[g] <= cfgWrData[SETUP_W-1:SEL_W];
        setupSel[g]  <= cfgWrData[SEL_W-1:0];
      end
    end

    assign strobe.capEn[g]  = (pc == setupStep[g]);
    assign strobe.capSel[g] = setupSel[g];

    // R6: setup changes only through its own address
    assert_setup_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
      !$past(wrHit[g]) |-> ($stable(setupStep[g]) && $stable(setupSel[g])));

    // R1: a write lands as {step, select}
    assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rstN)
      wrHit[g] |=> ({setupStep[g], setupSel[g]} == $past(cfgWrData)));
  end
endmodule

// File: rtl/capture_bank_dp.sv
module capture_bank_dp
  import capture_bank_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  capStrobe_t                      strobe,
  input  logic [DATA_W-1:0]               mulOut,
  input  logic [DATA_W-1:0]               dbOut,
  input  logic [DATA_W-1:0]               mulDin,
  input  logic [COEF_W-1:0]               coefIn,
  output logic [NUM_CAP-1:0][DATA_W-1:0]  capWord
);
  localparam int PAD_W = DATA_W - COEF_W;

  logic [DATA_W-1:0] coefWide;
  assign coefWide = {{PAD_W{1'b0}}, coefIn};

  for (genvar g = 0; g < NUM_CAP; g++) begin : gCap
    logic [DATA_W-1:0] srcVal;

    always_comb begin
      unique case (srcSel_e'(strobe.capSel[g]))
        SRC_MUL_OUT: srcVal = mulOut;
        SRC_DB_OUT:  srcVal = dbOut;
        SRC_MUL_DIN: srcVal = mulDin;
        default:     srcVal = coefWide;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN)                  capWord[g] <= '0;
      else if (strobe.capEn[g])   capWord[g] <= srcVal;
    end

    // R4: a capture only moves after a match
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
      !$past(strobe.capEn[g]) |-> $stable(capWord[g]));

    // R3: coefficient captures are zero-extended
    assert_coef_align_R3: assert property (@(posedge clk) disable iff (!rstN)
      ($past(strobe.capEn[g]) && ($past(strobe.capSel[g]) == SRC_COEF))
        |-> (capWord[g][DATA_W-1:COEF_W] == '0));

    // R3: select 00 captures the multiplier product
    assert_mul_path_R3: assert property (@(posedge clk) disable iff (!rstN)
      ($past(strobe.capEn[g]) && ($past(strobe.capSel[g]) == SRC_MUL_OUT))
        |-> (capWord[g] == $past(mulOut)));
  end
endmodule

// File: rtl/capture_bank.sv
module capture_bank
  import capture_bank_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [STEP_W-1:0]           pc,
  input  logic [DATA_W-1:0]           mulOut,
  input  logic [DATA_W-1:0]           dbOut,
  input  logic [DATA_W-1:0]           mulDin,
  input  logic [COEF_W-1:0]           coefIn,
  input  logic                        cfgWrEn,
  input  logic [ADDR_W-1:0]           cfgAddr,
  input  logic [SETUP_W-1:0]          cfgWrData,
  input  logic [ADDR_W-1:0]           rdAddr,
  output logic [DATA_W-1:0]           rdData,
  output logic [NUM_SER*DATA_W-1:0]   serWords
);
  capStrobe_t                     strobe;
  logic [NUM_CAP-1:0][DATA_W-1:0] capWord;

  capture_bank_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pc        (pc),
    .cfgWrEn   (cfgWrEn),
    .cfgAddr   (cfgAddr),
    .cfgWrData (cfgWrData),
    .strobe    (strobe)
  );

  capture_bank_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .mulOut  (mulOut),
    .dbOut   (dbOut),
    .mulDin  (mulDin),
    .coefIn  (coefIn),
    .capWord (capWord)
  );

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_RD; i++) begin
      if (rdAddr == ADDR_W'(BASE_ADDR + i)) rdData = capWord[i];
    end
  end

  for (genvar k = 0; k < NUM_SER; k++) begin : gSer
    assign serWords[k*DATA_W +: DATA_W] = capWord[NUM_RD + k];
  end
endmodule

// File: tb/capture_bank_bench.sv
module capture_bank_bench;
  logic         clk = 0;
  logic         rstN = 0;
  logic [8:0]   pc = '0;
  logic [23:0]  mulOut = '0, dbOut = '0, mulDin = '0;
  logic [21:0]  coefIn = '0;
  logic         cfgWrEn = 0;
  logic [8:0]   cfgAddr = '0;
  logic [10:0]  cfgWrData = '0;
  logic [8:0]   rdAddr = 9'd266;
  logic [23:0]  rdData;
  logic [143:0] serWords;

  int checks = 0, errors = 0, cycleCnt = 0;
  int expStep [8];
  int expSel [8];
  logic [23:0] expCap [8];

  always #10 clk = ~clk;

  capture_bank u_capture_bank (
    .clk(clk), .rstN(rstN), .pc(pc), .mulOut(mulOut), .dbOut(dbOut),
    .mulDin(mulDin), .coefIn(coefIn), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .rdAddr(rdAddr), .rdData(rdData), .serWords(serWords)
  );

  function automatic logic [23:0] busVal(int s, int p);
    logic [23:0] v;
    v = 24'((p + 1) * (2 * s + 3) * 40503 + s * 1234567);
    if (s == 3) v[23:22] = 2'b00;
    return v;
  endfunction

  task automatic check(string tag, int idx, logic [23:0] got, logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s cap%0d got %h expected %h", tag, idx, got, exp);
    end
  endtask

  task automatic readCap(int i, output logic [23:0] v);
    if (i < 2) begin
      rdAddr = 9'(266 + i);
      #1 v = rdData;
    end else begin
      v = serWords[(i-2)*24 +: 24];
    end
  endtask

  task automatic checkAll(string tag);
    logic [23:0] v;
    for (int i = 0; i < 8; i++) begin
      readCap(i, v);
      check(tag, i, v, expCap[i]);
    end
  endtask

  // One clock: drive at negedge, model update at posedge, check at next negedge
  task automatic doCycle(int p, bit we, int a, int d, string tag);
    pc = 9'(p);
    mulOut = busVal(0, p); dbOut = busVal(1, p);
    mulDin = busVal(2, p); coefIn = busVal(3, p)[21:0];
    cfgWrEn = we; cfgAddr = 9'(a); cfgWrData = 11'(d);
    @(posedge clk);
    for (int i = 0; i < 8; i++)
      if (p == expStep[i]) expCap[i] = busVal(expSel[i], p);
    if (we && a >= 266 && a <= 273) begin
      expStep[a-266] = (d >> 2) & 511;
      expSel[a-266]  = d & 3;
    end
    @(negedge clk);
    cfgWrEn = 0;
    checkAll(tag);
  endtask

  task automatic writeSetup(int a, int step, int sel, string tag);
    doCycle(511, 1'b1, a, (step << 2) | sel, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycleCnt++;
      if (cycleCnt > 200000) begin
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [23:0] v;
    for (int i = 0; i < 8; i++) begin
      expStep[i] = 0; expSel[i] = 0; expCap[i] = '0;
    end
    pc = 9'd100; mulOut = 24'hABCDEF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    checkAll("R9 reset clears captures");
    // R9 default setups: step 0 select 00, all capture together (R5)
    doCycle(0, 1'b0, 0, 0, "R9 R5 default setup");
    // R5: all share step 300 with mixed selects
    for (int i = 0; i < 8; i++) writeSetup(266 + i, 300, i % 4, "R1 setup");
    doCycle(299, 1'b0, 0, 0, "R4 no match");
    doCycle(300, 1'b0, 0, 0, "R5 shared step");
    // Sweep every register, select and program step
    for (int i = 0; i < 8; i++) begin
      for (int s = 0; s < 4; s++) begin
        writeSetup(266 + i, (i*61 + s*17 + 5) % 512, s, "R1 setup");
        for (int p = 0; p < 512; p++) doCycle(p, 1'b0, 0, 0, "R1 R2 R3 R4 R8 sweep");
      end
    end
    // R6: unmapped writes ignored
    writeSetup(265, 7, 1, "R6 unmapped");
    writeSetup(274, 7, 1, "R6 unmapped");
    writeSetup(0, 7, 1, "R6 unmapped");
    writeSetup(256, 7, 1, "R6 unmapped");
    for (int p = 0; p < 512; p++) doCycle(p, 1'b0, 0, 0, "R6 setups unchanged");
    // R10: a write on a matching edge uses the old setup
    doCycle(40, 1'b1, 266, (40 << 2) | 1, "R10 old setup on write edge");
    doCycle(40, 1'b0, 0, 0, "R10 new setup next edge");
    // R7: read port decode
    rdAddr = 9'd268; #1 check("R7 unmapped read", 2, rdData, 24'h0);
    rdAddr = 9'd265; #1 check("R7 unmapped read", 0, rdData, 24'h0);
    rdAddr = 9'd0;   #1 check("R7 unmapped read", 0, rdData, 24'h0);
    readCap(0, v); check("R7 read 266", 0, v, expCap[0]);
    readCap(1, v); check("R7 read 267", 1, v, expCap[1]);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule